// File: doc/BRIEF.md
# Exclusive Access Reservation Tracker

This block sits beside a memory-like AXI subordinate and decides the outcome of exclusive (locked) writes. It watches accepted read-address and write-address transfers. A read with the lock bit set opens a reservation for its transaction ID. A later write with the lock bit set is checked against that ID's reservation. Only an exact match on ID, start address and transfer size earns EXOKAY. Any other outcome is OKAY, and the write's data is then marked as not to be committed.

Each transaction ID owns exactly one reservation slot. Slots are cleared by several events: the owner's own exclusive write attempt, whether it wins or loses; any write whose byte footprint overlaps a slot owned by a different ID; and a plain write by the owner that overlaps its own slot. A newer exclusive read by an ID overwrites that ID's older slot. Only the start address and the beat size are tracked, so a burst behaves like a single beat at its start address.

The write verdict is registered. It appears on the response outputs in the cycle after the write snoop is presented, so the surrounding subordinate can attach it to its write response and gate its memory write. Handshakes on the response channels and the data storage itself belong to the surrounding logic.

Top module: `excl_resv_tracker`

## Requirements
- R1: Synchronous active-high reset empties every slot and drives rsp_valid low, so an exclusive write made right after reset gets OKAY.
- R2: A read snoop with rd_valid=1 and rd_lock=1 stores rd_addr and rd_size into the slot of rd_id and makes it live. A read snoop with rd_lock=0 changes nothing.
- R3: A write with wr_lock=1 whose wr_id slot is live with an equal address and an equal size returns rsp_code 2'b01 (EXOKAY) and empties that slot. An identical repeat then returns 2'b00 (OKAY).
- R4: An exclusive write by the slot owner at the same address but with a smaller or larger size returns 2'b00 and empties the slot.
- R5: An exclusive write by the slot owner to a different address returns 2'b00 and empties the slot.
- R6: A write footprint is [addr, addr + 2^size). Any write by a different ID, exclusive or not, that overlaps a live slot's footprint empties that slot, and a write that does not overlap leaves it intact. A non-exclusive overlapping write by the owner also empties the owner's slot.
- R7: A newer exclusive read by an ID replaces its earlier slot, so only the latest address and size can earn EXOKAY.
- R8: rsp_suppress is 1 exactly for an exclusive write that receives OKAY. It is 0 for EXOKAY and for every non-exclusive write.
- R9: rsp_valid is 1 in the cycle after each cycle with wr_valid=1 and 0 otherwise. Non-exclusive writes always return 2'b00.
- R10: When a read snoop and a write snoop arrive in the same cycle, the write is judged against the slots as they stood before that cycle, and the read's slot load then takes effect over any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Accepted read-address transfer this cycle |
| rd_lock | input | 1 | Read is exclusive |
| rd_id | input | ID_W | Read transaction ID |
| rd_addr | input | ADDR_W | Read start address |
| rd_size | input | SIZE_W | Read beat size, log2 bytes |
| wr_valid | input | 1 | Accepted write-address transfer this cycle |
| wr_lock | input | 1 | Write is exclusive |
| wr_id | input | ID_W | Write transaction ID |
| wr_addr | input | ADDR_W | Write start address |
| wr_size | input | SIZE_W | Write beat size, log2 bytes |
| rsp_valid | output | 1 | Verdict for the previous cycle's write |
| rsp_code | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |
| rsp_suppress | output | 1 | Memory must not commit this write's data |

## Verification
The bench goes after size mismatches in both directions. A tracker that compared only addresses would grant EXOKAY there. It also checks that a win consumes the slot; without that, an identical retry would succeed twice. Foreign writes are placed one byte inside and exactly at the edge of a reserved footprint, to catch off-by-one overlap arithmetic, which would either leave a stale reservation or wipe a neighbour's. Same-cycle read and write cases expose a wrong priority between load and clear. A long model-driven sweep over a small set of addresses and IDs mixes all of these with reset.

// File: rtl/excl_resv_pkg.sv
package excl_resv_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;
endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              wr_valid,
  input  logic              wr_lock,
  input  logic              wr_own,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  output logic              live,
  output logic              exact
);
  localparam int EXT_W = ADDR_W + 1;

  logic              live_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [EXT_W-1:0]  resv_end, wr_end;
  logic              ovl, clr;

  always_comb begin
    resv_end = {1'b0, addr_q} + (EXT_W'(1) << size_q);
    wr_end   = {1'b0, wr_addr} + (EXT_W'(1) << wr_size);
    ovl      = live_q && ({1'b0, wr_addr} < resv_end) && ({1'b0, addr_q} < wr_end);
    exact    = live_q && (addr_q == wr_addr) && (size_q == wr_size);
    clr      = wr_valid && (ovl || (wr_own && wr_lock));
  end

  always_ff @(posedge clk) begin
    if (rst)        live_q <= 1'b0;
    else if (ld_en) live_q <= 1'b1;
    else if (clr)   live_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      addr_q <= ld_addr;
      size_q <= ld_size;
    end
  end

  assign live = live_q;

  // R2
  load_sets_live_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> live_q);

  // R5
  own_excl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_own && wr_lock && !ld_en) |=> !live_q);

  // R6
  foreign_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_own && ovl && !ld_en) |=> !live_q);
endmodule

// File: rtl/excl_resv_judge.sv
module excl_resv_judge
  import excl_resv_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int NUM_IDS = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] exact_vec,
  input  logic               wr_valid,
  input  logic               wr_lock,
  input  logic [ID_W-1:0]    wr_id,
  output logic               rsp_valid,
  output logic [1:0]         rsp_code,
  output logic               rsp_suppress
);
  logic  grant;
  resp_e code_d;

  always_comb begin
    grant  = wr_valid && wr_lock && exact_vec[wr_id];
    code_d = grant ? RESP_EXOKAY : RESP_OKAY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= RESP_OKAY;
      rsp_suppress <= 1'b0;
    end else begin
      rsp_valid    <= wr_valid;
      rsp_code     <= code_d;
      rsp_suppress <= wr_valid && wr_lock && !grant;
    end
  end

  // R9
  rsp_follows_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> !rsp_valid);

  // R8
  exok_no_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_code == RESP_EXOKAY) |-> (!rsp_suppress && rsp_valid));

  // R8
  plain_no_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_lock) |=> !rsp_suppress);
endmodule

// File: rtl/excl_resv_tracker.sv
module excl_resv_tracker #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic              rd_lock,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic              wr_valid,
  input  logic              wr_lock,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              rsp_suppress
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] live_vec;
  logic [NUM_IDS-1:0] exact_vec;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic ld_hit, wr_hit;
    assign ld_hit = rd_valid && rd_lock && (rd_id == ID_W'(g));
    assign wr_hit = (wr_id == ID_W'(g));

    excl_resv_slot #(
      .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W)
    ) slot_i (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_hit),
      .ld_addr (rd_addr),
      .ld_size (rd_size),
      .wr_valid(wr_valid),
      .wr_lock (wr_lock),
      .wr_own  (wr_hit),
      .wr_addr (wr_addr),
      .wr_size (wr_size),
      .live    (live_vec[g]),
      .exact   (exact_vec[g])
    );
  end

  excl_resv_judge #(
    .ID_W(ID_W)
  ) judge_i (
    .clk         (clk),
    .rst         (rst),
    .exact_vec   (exact_vec),
    .wr_valid    (wr_valid),
    .wr_lock     (wr_lock),
    .wr_id       (wr_id),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_suppress(rsp_suppress)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    $past(rst) |-> (live_vec == '0 && !rsp_valid));
endmodule

// File: tb/excl_resv_tracker_tb.sv
module excl_resv_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4, ADDR_W = 16, SIZE_W = 3;
  localparam int NIDS = 1 << ID_W;

  logic clk = 0, rst = 1;
  logic rd_valid = 0, rd_lock = 0, wr_valid = 0, wr_lock = 0;
  logic [ID_W-1:0] rd_id = 0, wr_id = 0;
  logic [ADDR_W-1:0] rd_addr = 0, wr_addr = 0;
  logic [SIZE_W-1:0] rd_size = 0, wr_size = 0;
  logic rsp_valid, rsp_suppress;
  logic [1:0] rsp_code;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  bit m_live[NIDS];
  int m_addr[NIDS];
  int m_size[NIDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_resv_tracker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_id(rd_id), .rd_addr(rd_addr), .rd_size(rd_size),
    .wr_valid(wr_valid), .wr_lock(wr_lock), .wr_id(wr_id), .wr_addr(wr_addr), .wr_size(wr_size),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_suppress(rsp_suppress));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ov(int a1, int s1, int a2, int s2);
    return (a1 < a2 + (1 << s2)) && (a2 < a1 + (1 << s1));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NIDS; i++) m_live[i] = 0;
  endtask

  // One cycle with optional read and write snoops; checks verdict against the model.
  task automatic op(bit rv, bit rl, int rid, int ra, int rs,
                    bit wv, bit wl, int wid, int wa, int ws, string req);
    bit exp_ok;
    exp_ok = wv && wl && m_live[wid] && m_addr[wid] == wa && m_size[wid] == ws;
    if (wv)
      for (int i = 0; i < NIDS; i++)
        if (m_live[i] && (ov(m_addr[i], m_size[i], wa, ws) || (i == wid && wl))) m_live[i] = 0;
    if (rv && rl) begin
      m_live[rid] = 1; m_addr[rid] = ra; m_size[rid] = rs;
    end
    rd_valid = rv; rd_lock = rl; rd_id = ID_W'(rid); rd_addr = ADDR_W'(ra); rd_size = SIZE_W'(rs);
    wr_valid = wv; wr_lock = wl; wr_id = ID_W'(wid); wr_addr = ADDR_W'(wa); wr_size = SIZE_W'(ws);
    @(negedge clk);
    rd_valid = 0; wr_valid = 0;
    check({req, " rsp_valid"}, int'(rsp_valid), int'(wv));
    if (wv) begin
      check({req, " rsp_code"}, int'(rsp_code), exp_ok ? 1 : 0);
      check({req, " rsp_suppress"}, int'(rsp_suppress), (wl && !exp_ok) ? 1 : 0);
    end
  endtask

  task automatic rd(int id, int a, int s, bit lk = 1);
    op(1, lk, id, a, s, 0, 0, 0, 0, 0, "R2 read");
  endtask

  // Write with an explicit expected outcome in addition to the model.
  task automatic wr(int id, int a, int s, bit lk, bit exp_ex, string req);
    op(0, 0, 0, 0, 0, 1, lk, id, a, s, req);
    check({req, " explicit code"}, int'(rsp_code), exp_ex ? 1 : 0);
  endtask

  task automatic do_reset();
    rst = 1; model_reset();
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    for (int i = 0; i < NIDS; i++) wr(i, 'h1000, 3, 1, 0, "R1 empty slot");

    // R3 win then consumed
    rd(1, 'h1000, 3);
    wr(1, 'h1000, 3, 1, 1, "R3 exact match");
    wr(1, 'h1000, 3, 1, 0, "R3 repeat consumed");
    // R2 unlocked read ignored
    rd(2, 'h1000, 3, 0);
    wr(2, 'h1000, 3, 1, 0, "R2 unlocked read ignored");
    // R4 smaller and larger
    rd(2, 'h1000, 3);
    wr(2, 'h1000, 2, 1, 0, "R4 smaller size");
    wr(2, 'h1000, 3, 1, 0, "R4 cleared after smaller");
    rd(3, 'h1000, 0);
    wr(3, 'h1000, 2, 1, 0, "R4 larger size");
    wr(3, 'h1000, 0, 1, 0, "R4 cleared after larger");
    // R5 other address
    rd(3, 'h1000, 0);
    wr(3, 'h2000, 2, 1, 0, "R5 other address");
    wr(3, 'h1000, 0, 1, 0, "R5 cleared");
    // R6 foreign exact and partial overlap
    rd(4, 'h1000, 3);
    wr(1, 'h1000, 3, 1, 0, "R6 foreign exact");
    wr(4, 'h1000, 3, 1, 0, "R6 cleared by foreign exact");
    rd(5, 'h1000, 3);
    wr(2, 'h1000, 1, 1, 0, "R6 foreign partial");
    wr(5, 'h1000, 3, 1, 0, "R6 cleared by foreign partial");
    rd(5, 'h1000, 3);
    wr(2, 'h1007, 0, 0, 0, "R6 plain write last byte");
    wr(5, 'h1000, 3, 1, 0, "R6 cleared by plain write");
    rd(0, 'h1000, 3);
    wr(1, 'h1020, 3, 1, 0, "R6 foreign disjoint");
    wr(0, 'h1000, 3, 1, 1, "R6 disjoint keeps slot");
    rd(0, 'h1000, 3);
    wr(1, 'h1008, 3, 0, 0, "R6 adjacent edge");
    wr(0, 'h1000, 3, 1, 1, "R6 edge keeps slot");
    // R7 replacement
    rd(0, 'h1000, 3); rd(0, 'h2000, 3);
    wr(0, 'h1000, 3, 1, 0, "R7 old address lost");
    rd(0, 'h1000, 3); rd(0, 'h2000, 3);
    wr(0, 'h2000, 3, 1, 1, "R7 latest address wins");
    // burst start address only
    rd(1, 'h1000, 3);
    wr(1, 'h1008, 3, 1, 0, "R3 later beat fails");
    // R8 and R9 plain writes
    wr(6, 'h3000, 2, 0, 0, "R9 plain write okay");
    check("R8 plain no suppress", int'(rsp_suppress), 0);
    rd(7, 'h40, 1);
    check("R9 no rsp on read", int'(rsp_valid), 0);
    // R10 same cycle: write judged on old state, read loads
    rd(8, 'h500, 2);
    op(1, 1, 8, 'h600, 2, 1, 1, 8, 'h500, 2, "R10 same cycle win");
    wr(8, 'h600, 2, 1, 1, "R10 load survives own clear");
    op(1, 1, 9, 'h700, 3, 1, 0, 2, 'h700, 3, "R10 foreign overlap same cycle");
    wr(9, 'h700, 3, 1, 1, "R10 load beats foreign clear");
    // R1 mid-run reset
    rd(3, 'h100, 2);
    do_reset();
    wr(3, 'h100, 2, 1, 0, "R1 reset clears slot");

    // Size sweep for one ID: R3 and R4
    for (int sr = 0; sr < 8; sr++)
      for (int sw = 0; sw < 8; sw++) begin
        rd(10, 'h800, sr);
        wr(10, 'h800, sw, 1, sr == sw, sr == sw ? "R3 size sweep" : "R4 size sweep");
      end

    // Model-driven sweep
    for (int n = 0; n < 4000; n++) begin
      int pick, a_sel[5];
      a_sel = '{'h100, 'h102, 'h104, 'h108, 'h110};
      pick = $urandom_range(0, 99);
      if (pick == 0) do_reset();
      else op($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 3),
              a_sel[$urandom_range(0, 4)], $urandom_range(0, 3),
              $urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 3),
              a_sel[$urandom_range(0, 4)], $urandom_range(0, 3), "R10 sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule